// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns one 32-bit instruction word into the control bundle that an execute stage needs. The three top bits of the word pick one of three layouts. The first layout carries a short opcode with a 24-bit immediate, and covers branches, calls, return, no-operation and loading the stack pointer. The second layout carries a long opcode with two 8-bit register indices, and covers the ALU operations, halt, push, pop, a memory store and a register move. The third layout carries a short opcode, one register index and a 16-bit immediate, and loads either half of a register. Any word the decoder does not recognise raises an illegal-instruction flag.

The decoder is purely combinational, and the instruction's address passes through it unchanged. It sits on a valid/ready stream. The word and its address enter with `in_valid`, and the bundle leaves in the same cycle with `out_valid`. Back-pressure passes straight through: `in_ready` follows `out_ready`. The decoder holds no state, so a word is accepted in the cycle in which `in_valid` and `in_ready` are both high, and the upstream stage must hold the word steady until that cycle.

Top module: `instr_decoder`

## Requirements
- R1: Bits 31:29 select the layout. The values 0, 1 and 2 are legal. Any value from 3 to 7 sets `out_illegal`=1 and drives every other bundle field to zero.
- R2: In layout 0, with the opcode in bits 28:24, opcode 0x00 gives action 0 (no-operation) and opcode 0x10 gives action 3 (return). Both leave every other field zero.
- R3: Layout-0 opcodes 0x01 to 0x05 give action 1 (jump). The condition code is the opcode minus 1, where 0 means always, 1 zero, 2 not-zero, 3 carry and 4 not-carry. The destination mode is 3 (immediate) and `out_imm` is bits 23:0.
- R4: Layout-0 opcodes 0x11 to 0x15 give action 2 (call), with the same conditions, destination mode and immediate as R3. Opcode bit 4 is what separates a call from a jump.
- R5: Layout-0 opcode 0x0F gives action 5 (move), source-A mode 3 (immediate), destination mode 6 (stack pointer) and `out_imm` equal to bits 23:0.
- R6: In layout 1, the opcode is in bits 28:16, register A in bits 15:8 and register B in bits 7:0. Opcodes 0 to 4 give action 4 (ALU) and an ALU code equal to the opcode (0 add, 1 subtract, 2 shift left, 3 shift right, 4 compare). Source A, source B and the destination all use mode 1 (register). Add, subtract and compare name register B as the destination.
- R7: The two shifts (layout-1 opcodes 2 and 3) name register A as the destination.
- R8: Layout-1 opcodes 5, 6 and 7 give actions 6 (halt), 7 (push) and 8 (pop). Both sources use mode 1, with indices A and B, and the destination mode is 0.
- R9: Layout-1 opcode 8 gives action 5 with source A in mode 1, source B in mode 2 (indirect) and destination B in mode 2. Opcode 9 gives action 5 with source A in mode 1 and destination B in mode 1, with source-B mode 0.
- R10: In layout 2, the opcode is in bits 28:24, the register in bits 23:16 and the immediate in bits 15:0. Opcode 0 gives action 5, source-A mode 3 and destination mode 4 (low half). Opcode 1 does the same with destination mode 5 (high half). `out_imm` is the 16-bit field with zero extension.
- R11: Any opcode not listed for its layout sets `out_illegal`=1 and drives every other bundle field to zero.
- R12: `out_addr` equals `in_addr`, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`, all in the same cycle and with no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Decoder can take the word (follows out_ready) |
| in_instr | input | 32 | Instruction word |
| in_addr | input | ADDR_W | Address of the instruction |
| out_valid | output | 1 | Bundle present |
| out_ready | input | 1 | Downstream takes the bundle |
| out_act | output | 4 | Action code |
| out_alu | output | 3 | ALU operation code |
| out_cond | output | 3 | Branch condition code |
| out_src_a | output | 8 | Source A register index |
| out_src_b | output | 8 | Source B register index |
| out_dst | output | 8 | Destination register index |
| out_mode_a | output | 3 | Source A addressing mode |
| out_mode_b | output | 3 | Source B addressing mode |
| out_mode_d | output | 3 | Destination addressing mode |
| out_imm | output | 24 | Immediate value, zero-extended |
| out_addr | output | ADDR_W | Instruction address passed along |
| out_illegal | output | 1 | Illegal-instruction flag |

## Verification
Every result is due in the same cycle as its stimulus, because no register stands between any input and any output. The bench drives a new word shortly after a rising edge and compares the whole bundle at the following falling edge. This leaves half a period for the inputs to settle, and no edge falls between the drive and the compare. The handshake pins and the address are compared in that same window.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 8;
  localparam int IMM_W  = 24;
  localparam int HALF_W = 16;
  localparam int FMT_LO = WORD_W - 3;

  typedef enum logic [3:0] {
    ACT_NOP = 4'd0, ACT_JUMP = 4'd1, ACT_CALL = 4'd2, ACT_RET = 4'd3,
    ACT_ALU = 4'd4, ACT_MOVE = 4'd5, ACT_HALT = 4'd6, ACT_PUSH = 4'd7,
    ACT_POP = 4'd8
  } act_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_SHL = 3'd2, ALU_SHR = 3'd3, ALU_CMP = 3'd4
  } alu_e;

  typedef enum logic [2:0] {
    CND_ALWAYS = 3'd0, CND_Z = 3'd1, CND_NZ = 3'd2, CND_C = 3'd3, CND_NC = 3'd4
  } cond_e;

  typedef enum logic [2:0] {
    MD_NONE = 3'd0, MD_REG = 3'd1, MD_IND = 3'd2, MD_IMM = 3'd3,
    MD_LO = 3'd4, MD_HI = 3'd5, MD_SP = 3'd6
  } mode_e;

  typedef struct packed {
    act_e              act;
    alu_e              alu;
    cond_e             cnd;
    logic [IDX_W-1:0]  a_idx;
    logic [IDX_W-1:0]  b_idx;
    logic [IDX_W-1:0]  d_idx;
    mode_e             a_md;
    mode_e             b_md;
    mode_e             d_md;
    logic [IMM_W-1:0]  imm;
    logic              bad;
  } dec_t;

  localparam dec_t DEC_BAD = '{act: ACT_NOP, alu: ALU_ADD, cnd: CND_ALWAYS,
                               a_idx: '0, b_idx: '0, d_idx: '0,
                               a_md: MD_NONE, b_md: MD_NONE, d_md: MD_NONE,
                               imm: '0, bad: 1'b1};
endpackage

// File: rtl/idec_fmt0.sv
module idec_fmt0
  import idec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              d
);
  logic [4:0] op;
  assign op = word[FMT_LO-1 -: 5];

  always_comb begin
    d = '0;
    case (op)
      5'h00: d.act = ACT_NOP;
      5'h10: d.act = ACT_RET;
      5'h01, 5'h02, 5'h03, 5'h04, 5'h05,
      5'h11, 5'h12, 5'h13, 5'h14, 5'h15: begin
        d.act  = op[4] ? ACT_CALL : ACT_JUMP;
        d.cnd  = cond_e'(op[2:0] - 3'd1);
        d.d_md = MD_IMM;
        d.imm  = word[IMM_W-1:0];
      end
      5'h0F: begin
        d.act  = ACT_MOVE;
        d.a_md = MD_IMM;
        d.d_md = MD_SP;
        d.imm  = word[IMM_W-1:0];
      end
      default: d = DEC_BAD;
    endcase
  end
endmodule

// File: rtl/idec_fmt1.sv
module idec_fmt1
  import idec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              d
);
  localparam int OP_W = FMT_LO - 2 * IDX_W;
  logic [OP_W-1:0]  op;
  logic [IDX_W-1:0] ra, rb;
  assign op = word[FMT_LO-1 -: OP_W];
  assign ra = word[2*IDX_W-1 -: IDX_W];
  assign rb = word[IDX_W-1:0];

  always_comb begin
    d       = '0;
    d.a_idx = ra;
    d.b_idx = rb;
    case (op)
      OP_W'(0), OP_W'(1), OP_W'(2), OP_W'(3), OP_W'(4): begin
        d.act   = ACT_ALU;
        d.alu   = alu_e'(op[2:0]);
        d.a_md  = MD_REG;
        d.b_md  = MD_REG;
        d.d_md  = MD_REG;
        d.d_idx = (op == OP_W'(2) || op == OP_W'(3)) ? ra : rb;
      end
      OP_W'(5), OP_W'(6), OP_W'(7): begin
        d.act  = (op == OP_W'(5)) ? ACT_HALT : (op == OP_W'(6)) ? ACT_PUSH : ACT_POP;
        d.a_md = MD_REG;
        d.b_md = MD_REG;
      end
      OP_W'(8): begin
        d.act   = ACT_MOVE;
        d.a_md  = MD_REG;
        d.b_md  = MD_IND;
        d.d_md  = MD_IND;
        d.d_idx = rb;
      end
      OP_W'(9): begin
        d.act   = ACT_MOVE;
        d.a_md  = MD_REG;
        d.d_md  = MD_REG;
        d.d_idx = rb;
      end
      default: d = DEC_BAD;
    endcase
  end
endmodule

// File: rtl/idec_fmt2.sv
module idec_fmt2
  import idec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              d
);
  logic [4:0] op;
  assign op = word[FMT_LO-1 -: 5];

  always_comb begin
    d = '0;
    if (op == 5'd0 || op == 5'd1) begin
      d.act   = ACT_MOVE;
      d.a_md  = MD_IMM;
      d.d_md  = op[0] ? MD_HI : MD_LO;
      d.d_idx = word[HALF_W + IDX_W - 1 -: IDX_W];
      d.imm   = IMM_W'(word[HALF_W-1:0]);
    end else begin
      d = DEC_BAD;
    end
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import idec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_instr,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_act,
  output logic [2:0]        out_alu,
  output logic [2:0]        out_cond,
  output logic [7:0]        out_src_a,
  output logic [7:0]        out_src_b,
  output logic [7:0]        out_dst,
  output logic [2:0]        out_mode_a,
  output logic [2:0]        out_mode_b,
  output logic [2:0]        out_mode_d,
  output logic [23:0]       out_imm,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_illegal
);
  localparam int NFMT = 3;
  dec_t per_fmt [NFMT];
  dec_t sel;

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    if (g == 0) begin : g_f0
      idec_fmt0 u_f (.word(in_instr), .d(per_fmt[g]));
    end else if (g == 1) begin : g_f1
      idec_fmt1 u_f (.word(in_instr), .d(per_fmt[g]));
    end else begin : g_f2
      idec_fmt2 u_f (.word(in_instr), .d(per_fmt[g]));
    end
  end

  always_comb begin
    case (in_instr[WORD_W-1:FMT_LO])
      3'd0:    sel = per_fmt[0];
      3'd1:    sel = per_fmt[1];
      3'd2:    sel = per_fmt[2];
      default: sel = DEC_BAD;
    endcase
  end

  assign in_ready    = out_ready;
  assign out_valid   = in_valid;
  assign out_addr    = in_addr;
  assign out_act     = sel.act;
  assign out_alu     = sel.alu;
  assign out_cond    = sel.cnd;
  assign out_src_a   = sel.a_idx;
  assign out_src_b   = sel.b_idx;
  assign out_dst     = sel.d_idx;
  assign out_mode_a  = sel.a_md;
  assign out_mode_b  = sel.b_md;
  assign out_mode_d  = sel.d_md;
  assign out_imm     = sel.imm;
  assign out_illegal = sel.bad;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk (
  input logic [31:0] in_instr,
  input logic [3:0]  out_act,
  input logic [2:0]  out_alu,
  input logic [2:0]  out_cond,
  input logic [7:0]  out_dst,
  input logic [2:0]  out_mode_a,
  input logic [2:0]  out_mode_d,
  input logic [23:0] out_imm,
  input logic        out_illegal
);
  always_comb begin
    if (in_instr[31:29] > 3'd2)
      a_r1_bad_format: assert (out_illegal);
    if (out_illegal)
      a_r11_bad_is_quiet: assert (out_act == 4'd0 && out_mode_a == 3'd0 &&
                                  out_mode_d == 3'd0 && out_imm == 24'd0 && out_dst == 8'd0);
    if (out_act == 4'd1 || out_act == 4'd2)
      a_r3_branch_target: assert (out_cond <= 3'd4 && out_mode_d == 3'd3);
    if (out_act == 4'd4)
      a_r6_alu_code: assert (out_alu <= 3'd4 && out_mode_d == 3'd1);
    if (out_mode_d == 3'd4 || out_mode_d == 3'd5)
      a_r10_half_imm: assert (out_imm[23:16] == 8'd0 && out_mode_a == 3'd3);
  end
endmodule

bind instr_decoder instr_decoder_chk u_chk (
  .in_instr(in_instr), .out_act(out_act), .out_alu(out_alu), .out_cond(out_cond),
  .out_dst(out_dst), .out_mode_a(out_mode_a), .out_mode_d(out_mode_d),
  .out_imm(out_imm), .out_illegal(out_illegal)
);

// File: tb/instr_decoder_tb.sv
module instr_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic        in_ready, out_valid, out_illegal;
  logic [31:0] in_instr = '0, in_addr = '0, out_addr;
  logic [3:0]  out_act;
  logic [2:0]  out_alu, out_cond, out_mode_a, out_mode_b, out_mode_d;
  logic [7:0]  out_src_a, out_src_b, out_dst;
  logic [23:0] out_imm;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  instr_decoder u_dut (
    .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_act(out_act), .out_alu(out_alu),
    .out_cond(out_cond), .out_src_a(out_src_a), .out_src_b(out_src_b), .out_dst(out_dst),
    .out_mode_a(out_mode_a), .out_mode_b(out_mode_b), .out_mode_d(out_mode_d),
    .out_imm(out_imm), .out_addr(out_addr), .out_illegal(out_illegal)
  );

  // packed: act4 alu3 cond3 a8 b8 d8 ma3 mb3 md3 imm24 bad1
  function automatic logic [67:0] pack(int act, int alu, int cnd, int a, int b, int d,
                                       int ma, int mb, int md, logic [23:0] imm, bit bad);
    return {4'(act), 3'(alu), 3'(cnd), 8'(a), 8'(b), 8'(d), 3'(ma), 3'(mb), 3'(md), imm, bad};
  endfunction

  function automatic logic [67:0] ref_dec(logic [31:0] w);
    logic [67:0] bad_v = pack(0,0,0,0,0,0,0,0,0,24'd0,1'b1);
    int op5 = int'(w[28:24]);
    int op13 = int'(w[28:16]);
    int a = int'(w[15:8]);
    int b = int'(w[7:0]);
    case (w[31:29])
      3'd0: begin
        if (op5 == 0) return pack(0,0,0,0,0,0,0,0,0,24'd0,1'b0);
        if (op5 == 16) return pack(3,0,0,0,0,0,0,0,0,24'd0,1'b0);
        if (op5 >= 1 && op5 <= 5) return pack(1,0,op5-1,0,0,0,0,0,3,w[23:0],1'b0);
        if (op5 >= 17 && op5 <= 21) return pack(2,0,op5-17,0,0,0,0,0,3,w[23:0],1'b0);
        if (op5 == 15) return pack(5,0,0,0,0,0,3,0,6,w[23:0],1'b0);
        return bad_v;
      end
      3'd1: begin
        if (op13 <= 4) return pack(4,op13,0,a,b,(op13==2||op13==3)?a:b,1,1,1,24'd0,1'b0);
        if (op13 >= 5 && op13 <= 7) return pack(op13+1,0,0,a,b,0,1,1,0,24'd0,1'b0);
        if (op13 == 8) return pack(5,0,0,a,b,b,1,2,2,24'd0,1'b0);
        if (op13 == 9) return pack(5,0,0,a,b,b,1,0,1,24'd0,1'b0);
        return bad_v;
      end
      3'd2: begin
        if (op5 <= 1) return pack(5,0,0,0,0,int'(w[23:16]),3,0,4+op5,{8'd0,w[15:0]},1'b0);
        return bad_v;
      end
      default: return bad_v;
    endcase
  endfunction

  function automatic string tag_of(logic [31:0] w);
    int op5 = int'(w[28:24]);
    int op13 = int'(w[28:16]);
    case (w[31:29])
      3'd0: begin
        if (op5 == 0 || op5 == 16) return "R2";
        if (op5 >= 1 && op5 <= 5) return "R3";
        if (op5 >= 17 && op5 <= 21) return "R4";
        if (op5 == 15) return "R5";
        return "R11";
      end
      3'd1: begin
        if (op13 == 2 || op13 == 3) return "R7";
        if (op13 <= 4) return "R6";
        if (op13 <= 7) return "R8";
        if (op13 <= 9) return "R9";
        return "R11";
      end
      3'd2: return (op5 <= 1) ? "R10" : "R11";
      default: return "R1";
    endcase
  endfunction

  task automatic apply(logic [31:0] w, logic [31:0] addr, logic v, logic r);
    logic [67:0] got, exp;
    @(posedge clk); #2;
    in_instr = w; in_addr = addr; in_valid = v; out_ready = r;
    @(negedge clk);
    got = {out_act, out_alu, out_cond, out_src_a, out_src_b, out_dst,
           out_mode_a, out_mode_b, out_mode_d, out_imm, out_illegal};
    exp = ref_dec(w);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s word=%h actual=%h expected=%h", tag_of(w), w, got, exp);
    end
    n_run++;
    if (out_addr !== addr || out_valid !== v || in_ready !== r) begin
      n_fail++;
      $display("FAIL R12 actual addr=%h v=%b rdy=%b expected addr=%h v=%b rdy=%b",
               out_addr, out_valid, in_ready, addr, v, r);
    end
  endtask

  initial begin
    int unsigned seed = 32'd1234;
    logic [31:0] w;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R2 reset-time state: zero word, idle handshake
    apply(32'h0000_0000, 32'h0, 1'b0, 1'b0);
    // R3/R4 every condition, both branch kinds
    for (int k = 1; k <= 5; k++) apply({3'd0, 5'(k), 24'hABCDEF}, 32'h100 + k, 1'b1, 1'b1);
    for (int k = 17; k <= 21; k++) apply({3'd0, 5'(k), 24'h00FFFF}, 32'h200 + k, 1'b1, 1'b0);
    apply({3'd0, 5'h10, 24'h123456}, 32'h300, 1'b1, 1'b1);   // R2 return
    apply({3'd0, 5'h0F, 24'hFFFFFF}, 32'h304, 1'b1, 1'b1);   // R5
    apply({3'd0, 5'h06, 24'h0}, 32'h308, 1'b1, 1'b1);        // R11 gap opcode
    apply({3'd0, 5'h16, 24'h0}, 32'h30C, 1'b1, 1'b1);        // R11 just past calls
    for (int k = 0; k <= 10; k++) apply({3'd1, 13'(k), 8'h5A, 8'hC3}, 32'h400 + 4*k, 1'b1, 1'b1); // R6-R9, R11
    apply({3'd1, 13'h1FFF, 16'hFFFF}, 32'h500, 1'b1, 1'b1);  // R11
    apply({3'd2, 5'd0, 8'hFF, 16'hBEEF}, 32'h504, 1'b1, 1'b1); // R10 low
    apply({3'd2, 5'd1, 8'h01, 16'h8001}, 32'h508, 1'b1, 1'b1); // R10 high
    apply({3'd2, 5'd2, 8'h01, 16'h0}, 32'h50C, 1'b1, 1'b1);    // R11
    for (int k = 3; k <= 7; k++) apply({3'(k), 29'h0}, 32'hFFFF_FFF0, 1'b0, 1'b1); // R1
    for (int i = 0; i < 600; i++) begin
      w = $urandom();
      case (i % 4)
        0: w[28:24] = 5'($urandom_range(0, 22));
        1: w[28:16] = 13'($urandom_range(0, 11));
        2: w[28:24] = 5'($urandom_range(0, 3));
        default: ;
      endcase
      if (i % 4 != 3) w[31:29] = 3'(i % 3);
      apply(w, $urandom(), 1'($urandom()), 1'($urandom()));
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule